// File: doc/BRIEF.md
# Strap-Selected Serial Configuration Port

This block is the slave end of a three-wire control link that reaches a bank of sixteen 8-bit configuration registers. The host raises an enable line, then clocks in an 8-bit address word and an 8-bit data word, both least significant bit first. Address bit 0 picks the direction. Bits 1 and 2 are compared with two chip-select strap inputs. Bits 3 to 6 pick the register, and bit 7 is don't-care. A third strap, active low, switches the part into broadcast mode. In that mode every device on the link accepts a frame whose two select bits are both 1, whatever its own straps are.

A write takes effect only when the enable line falls. The last eight bits clocked before that edge go into the chosen register. A frame that ends early changes nothing. A read loads the chosen register into an output shifter as soon as the eighth address bit arrives and drives bit 0 at once. Each later falling edge of the serial clock moves the output to the next bit. The output enable drops after the eighth bit has been presented, or as soon as the enable line goes low.

The block runs on a fast system clock and treats the enable, serial clock and data inputs as signals already brought into that clock domain. It detects their edges internally. The core logic reads any register at any time through a separate parallel port.

Top module: `sercfg_port`

## Requirements
- R1: A frame with address bit a0 = 0 and 16 bits clocked in, followed by the enable line falling, writes data bits d0..d7 (LSB first) into the register selected by a6..a3. The new value appears on the parallel read port from the second system clock after the enable line falls.
- R2: While the broadcast strap is high, a frame is accepted only if a1 equals chip-select strap 0 and a2 equals chip-select strap 1. Any other frame writes nothing and never asserts the output enable.
- R3: While the broadcast strap is low, a frame is accepted only when a1 = a2 = 1, whatever the chip-select straps are. A frame whose a1/a2 only match the straps is ignored.
- R4: The register index comes from a6..a3 only. a7 has no effect on which register is written.
- R5: If the enable line falls after fewer than 16 serial clock rising edges in a write frame, no register changes.
- R6: If more than 16 bits are clocked in a write frame, the bit counter saturates without wrapping, and the last eight bits received are written.
- R7: In a read frame (a0 = 1), the selected register's d0 is on the data output, with the output enable high, from the eighth rising edge. Bits d1..d7 follow on the next seven falling edges.
- R8: The output enable goes low on the eighth falling edge after the read data was loaded. It also goes low within one system clock after the enable line goes low in the middle of a read.
- R9: If the enable line falls before eight address bits have been received, the frame is ignored: nothing is written and the output enable stays low.
- R10: A synchronous active-high reset clears all sixteen registers to zero and forces the output enable low. After reset, a frame is recognised only after a new rising edge of the enable line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Frame enable from the host, high during a frame |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data toward the host |
| ser_doe | output | 1 | Drive enable for the shared data line |
| strap_sel0 | input | 1 | Chip-select strap compared with a1 |
| strap_sel1 | input | 1 | Chip-select strap compared with a2 |
| strap_bcast_n | input | 1 | Low selects broadcast acceptance |
| core_idx | input | 4 | Register index for the core read port |
| core_data | output | 8 | Contents of the register at core_idx |

## Verification
Writes are tried with exactly 16 bits, with 15 bits, with 20 bits and with the address cut off after a few bits. Each case shows a different outcome on the parallel port: commit, drop, last-eight capture or no effect. The strap decode is exercised with matching and mismatching select bits, in both broadcast and normal mode, so a swapped or missing comparison writes a register that should stay unchanged. Reads are captured bit by bit during the high phase of the serial clock, both through to completion and when cut short. This checks the output data ordering and each of the points where the output enable may drop. A reset in the middle of a frame, with enable held high, shows both register clearing and the need for a fresh enable edge.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int ADDR_BITS  = 8;
    localparam int DATA_BITS  = 8;
    localparam int IDX_BITS   = 4;
    localparam int FRAME_BITS = ADDR_BITS + DATA_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // field positions inside the address word (behavioural: host encodes them)
    localparam int POS_DIR  = 0;
    localparam int POS_SEL0 = 1;
    localparam int POS_SEL1 = 2;
    localparam int POS_IDX  = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic                is_read;
        logic                sel0;
        logic                sel1;
        logic [IDX_BITS-1:0] idx;
    } addr_fields_t;

    function automatic addr_fields_t split_addr(input logic [ADDR_BITS-1:0] word);
        addr_fields_t f;
        f.is_read = word[POS_DIR];
        f.sel0    = word[POS_SEL0];
        f.sel1    = word[POS_SEL1];
        f.idx     = word[POS_IDX +: IDX_BITS];
        return f;
    endfunction

    function automatic logic frame_accepted(input addr_fields_t f,
                                            input logic cs0,
                                            input logic cs1,
                                            input logic bcast_n);
        if (!bcast_n)
            return f.sel0 & f.sel1;
        return (f.sel0 == cs0) && (f.sel1 == cs1);
    endfunction

endpackage

// File: rtl/sercfg_edges.sv
module sercfg_edges (
    input  logic clk,
    input  logic rst,
    input  logic ser_en,
    input  logic ser_clk,
    output logic en_rise,
    output logic en_fall,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic en_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            // enable treated as already high so a level held through reset is no edge
            en_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            en_q   <= ser_en;
            sclk_q <= ser_clk;
        end
    end

    assign en_rise   =  ser_en & ~en_q;
    assign en_fall   = ~ser_en &  en_q;
    assign sclk_rise =  ser_clk & ~sclk_q;
    assign sclk_fall = ~ser_clk &  sclk_q;

endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank #(
    parameter int DW = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data
);
    localparam int NREG = 1 << IW;

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                regs[g] <= wr_data;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

    // R1: a commit request lands in the addressed register
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data));

    // R10: reset leaves the addressed storage empty
    a_r10_cleared: assert property (@(posedge clk)
        rst |=> regs[rb_idx] == '0 || $past(wr_en));

endmodule

// File: rtl/sercfg_frame.sv
module sercfg_frame
    import sercfg_pkg::*;
#(
    parameter int AW = ADDR_BITS,
    parameter int DW = DATA_BITS,
    parameter int IW = IDX_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_en,
    input  logic          ser_din,
    input  logic          en_rise,
    input  logic          en_fall,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cs0,
    input  logic          cs1,
    input  logic          bcast_n,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic [IW-1:0] look_idx,
    input  logic [DW-1:0] look_data,
    output logic          sdo,
    output logic          doe
);
    localparam int FULL  = AW + DW;
    localparam int CW    = $clog2(FULL + 1);
    localparam int SW    = $clog2(DW);
    localparam logic [CW-1:0] CNT_FULL  = CW'(FULL);
    localparam logic [CW-1:0] CNT_ADDRL = CW'(AW - 1);
    localparam logic [SW-1:0] SENT_LAST = SW'(DW - 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [AW-1:0] ash;
    logic [DW-1:0] dsh;
    logic [DW-1:0] tx;
    logic [SW-1:0] sent;
    logic [IW-1:0] idx_q;

    logic [AW-1:0] addr_next;
    addr_fields_t  fld;
    logic          accept;

    assign addr_next = {ser_din, ash[AW-1:1]};
    assign fld       = split_addr(addr_next);
    assign accept    = frame_accepted(fld, cs0, cs1, bcast_n);
    assign look_idx  = fld.idx;

    assign wr_en   = (phase == PH_WDATA) && en_fall && (cnt == CNT_FULL);
    assign wr_idx  = idx_q;
    assign wr_data = dsh;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            ash   <= '0;
            dsh   <= '0;
            tx    <= '0;
            sent  <= '0;
            idx_q <= '0;
            sdo   <= 1'b0;
            doe   <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (en_rise) begin
                        phase <= PH_ADDR;
                        cnt   <= '0;
                    end
                end
                PH_ADDR: begin
                    if (!ser_en) begin
                        phase <= PH_IDLE;
                    end else if (sclk_rise) begin
                        ash <= addr_next;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_ADDRL) begin
                            if (!accept) begin
                                phase <= PH_HOLD;
                            end else if (fld.is_read) begin
                                phase <= PH_RDATA;
                                tx    <= look_data;
                                sdo   <= look_data[0];
                                doe   <= 1'b1;
                                sent  <= '0;
                            end else begin
                                phase <= PH_WDATA;
                                idx_q <= fld.idx;
                            end
                        end
                    end
                end
                PH_WDATA: begin
                    if (!ser_en) begin
                        phase <= PH_IDLE;
                    end else if (sclk_rise) begin
                        dsh <= {ser_din, dsh[DW-1:1]};
                        if (cnt != CNT_FULL)
                            cnt <= cnt + 1'b1;
                    end
                end
                PH_RDATA: begin
                    if (!ser_en) begin
                        phase <= PH_IDLE;
                        doe   <= 1'b0;
                        sdo   <= 1'b0;
                    end else if (sclk_fall) begin
                        if (sent == SENT_LAST) begin
                            phase <= PH_HOLD;
                            doe   <= 1'b0;
                            sdo   <= 1'b0;
                        end else begin
                            tx   <= tx >> 1;
                            sdo  <= tx[1];
                            sent <= sent + 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (!ser_en)
                        phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R8: enable low always releases the data line by the next cycle
    a_r8_release_on_en_low: assert property (@(posedge clk) disable iff (rst)
        !ser_en |=> !doe);

    // R7: read data only moves on a serial falling edge
    a_r7_bit_held: assert property (@(posedge clk) disable iff (rst)
        (doe && ser_en && !sclk_fall) |=> $stable(sdo));

    // R6: bit counter never passes the full frame length
    a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_FULL);

    // R10: reset returns the control state to idle with the line released
    a_r10_idle_after_reset: assert property (@(posedge clk)
        rst |=> (phase == PH_IDLE) && !doe);

    // R9: the output enable only rises on a serial rising edge
    a_r9_doe_on_rise_only: assert property (@(posedge clk) disable iff (rst)
        $rose(doe) |-> $past(sclk_rise));

endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
    import sercfg_pkg::*;
#(
    parameter int AW = ADDR_BITS,
    parameter int DW = DATA_BITS,
    parameter int IW = IDX_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_en,
    input  logic          ser_clk,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          ser_doe,
    input  logic          strap_sel0,
    input  logic          strap_sel1,
    input  logic          strap_bcast_n,
    input  logic [IW-1:0] core_idx,
    output logic [DW-1:0] core_data
);
    logic          en_rise, en_fall, sclk_rise, sclk_fall;
    logic          wr_en;
    logic [IW-1:0] wr_idx, look_idx;
    logic [DW-1:0] wr_data, look_data;

    sercfg_edges u_edges (
        .clk      (clk),
        .rst      (rst),
        .ser_en   (ser_en),
        .ser_clk  (ser_clk),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall)
    );

    sercfg_frame #(.AW(AW), .DW(DW), .IW(IW)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .ser_en   (ser_en),
        .ser_din  (ser_din),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cs0      (strap_sel0),
        .cs1      (strap_sel1),
        .bcast_n  (strap_bcast_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .look_idx (look_idx),
        .look_data(look_data),
        .sdo      (ser_dout),
        .doe      (ser_doe)
    );

    sercfg_regbank #(.DW(DW), .IW(IW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .ra_idx (core_idx),
        .ra_data(core_data),
        .rb_idx (look_idx),
        .rb_data(look_data)
    );

endmodule

// File: tb/test_sercfg_port.sv
module test_sercfg_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_en = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_dout;
    logic       ser_doe;
    logic       strap_sel0 = 1'b1;
    logic       strap_sel1 = 1'b0;
    logic       strap_bcast_n = 1'b1;
    logic [3:0] core_idx = '0;
    logic [7:0] core_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic cap_d  [24];
    logic cap_oe [24];
    logic end_oe;

    always #10 clk = ~clk;

    sercfg_port i_sercfg_port (
        .clk          (clk),
        .rst          (rst),
        .ser_en       (ser_en),
        .ser_clk      (ser_clk),
        .ser_din      (ser_din),
        .ser_dout     (ser_dout),
        .ser_doe      (ser_doe),
        .strap_sel0   (strap_sel0),
        .strap_sel1   (strap_sel1),
        .strap_bcast_n(strap_bcast_n),
        .core_idx     (core_idx),
        .core_data    (core_data)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic rd, input logic a1, input logic a2,
                                      input logic [3:0] idx, input logic a7);
        return {a7, idx, a2, a1, rd};
    endfunction

    // shift n bits; capture data/oe in each high phase; end_oe after last fall
    task automatic shift_bits(input logic [23:0] bits, input int n, input bit raise_en);
        if (raise_en) begin
            ser_en = 1'b1;
            wclk(3);
        end
        for (int i = 0; i < n; i++) begin
            ser_din = bits[i];
            wclk(2);
            ser_clk = 1'b1;
            wclk(3);
            cap_d[i]  = ser_dout;
            cap_oe[i] = ser_doe;
            ser_clk = 1'b0;
            wclk(3);
        end
        end_oe = ser_doe;
    endtask

    task automatic drop_en;
        ser_en = 1'b0;
        wclk(4);
    endtask

    task automatic frame(input logic [23:0] bits, input int n);
        shift_bits(bits, n, 1'b1);
        drop_en();
    endtask

    task automatic peek(input logic [3:0] idx, input string req, input logic [7:0] exp);
        core_idx = idx;
        wclk(1);
        check(req, core_data, exp);
    endtask

    task automatic t_reset_state;
        for (int i = 0; i < 16; i++) peek(4'(i), "R10 reset clear", 8'h00);
        check("R10 oe after reset", ser_doe, 1'b0);
    endtask

    task automatic t_basic_write;
        frame({8'hA5, mk(0, 1, 0, 4'd5, 0)}, 16);
        peek(4'd5, "R1 write idx5", 8'hA5);
        frame({8'h3C, mk(0, 1, 0, 4'd3, 1)}, 16);
        peek(4'd3, "R4 a7 set idx3", 8'h3C);
        peek(4'd11, "R4 idx11 untouched", 8'h00);
    endtask

    task automatic t_select_mismatch;
        frame({8'h11, mk(0, 0, 0, 4'd5, 0)}, 16);
        peek(4'd5, "R2 a1 mismatch", 8'hA5);
        frame({8'h22, mk(0, 1, 1, 4'd5, 0)}, 16);
        peek(4'd5, "R2 a2 mismatch", 8'hA5);
        frame({8'h00, mk(1, 0, 1, 4'd5, 0)}, 15);
        check("R2 mismatched read oe", cap_oe[7] | cap_oe[10], 1'b0);
    endtask

    task automatic t_broadcast;
        strap_bcast_n = 1'b0;
        wclk(2);
        frame({8'h77, mk(0, 1, 1, 4'd7, 0)}, 16);
        peek(4'd7, "R3 broadcast write", 8'h77);
        frame({8'h11, mk(0, 1, 0, 4'd7, 0)}, 16);
        peek(4'd7, "R3 strap match ignored", 8'h77);
        strap_bcast_n = 1'b1;
        wclk(2);
        frame({8'h99, mk(0, 1, 1, 4'd7, 0)}, 16);
        peek(4'd7, "R2 both-one without broadcast", 8'h77);
    endtask

    task automatic t_short_write;
        frame({8'hFF, mk(0, 1, 0, 4'd5, 0)}, 15);
        peek(4'd5, "R5 15-bit write dropped", 8'hA5);
    endtask

    task automatic t_long_write;
        frame({8'h5A, 4'h3, mk(0, 1, 0, 4'd9, 0)}, 20);
        peek(4'd9, "R6 last eight of 20", 8'h5A);
    endtask

    task automatic t_addr_abort;
        frame({8'hEE, mk(0, 1, 0, 4'd12, 0)}, 5);
        peek(4'd12, "R9 write cut in address", 8'h00);
        frame({8'h00, mk(1, 1, 0, 4'd5, 0)}, 7);
        check("R9 read cut in address oe", cap_oe[6] | end_oe, 1'b0);
    endtask

    task automatic t_read(input logic [3:0] idx, input logic [7:0] exp);
        logic [7:0] got;
        logic       all_oe;
        shift_bits({8'h00, mk(1, 1, 0, idx, 0)}, 15, 1'b1);
        all_oe = 1'b1;
        for (int i = 0; i < 8; i++) begin
            got[i] = cap_d[7 + i];
            all_oe = all_oe & cap_oe[7 + i];
        end
        check("R7 read data", got, exp);
        check("R7 oe during data", all_oe, 1'b1);
        check("R8 oe after eighth fall", end_oe, 1'b0);
        drop_en();
    endtask

    task automatic t_read_abort;
        shift_bits({8'h00, mk(1, 1, 0, 4'd5, 0)}, 11, 1'b1);
        check("R8 oe before abort", cap_oe[10], 1'b1);
        ser_en = 1'b0;
        wclk(2);
        check("R8 oe after abort", ser_doe, 1'b0);
        wclk(2);
    endtask

    task automatic t_reset_mid_frame;
        ser_en = 1'b1;
        wclk(3);
        rst = 1'b1;
        wclk(2);
        rst = 1'b0;
        wclk(2);
        shift_bits({8'hFF, mk(0, 1, 0, 4'd2, 0)}, 16, 1'b0);
        drop_en();
        peek(4'd2, "R10 no frame without new rise", 8'h00);
        peek(4'd5, "R10 reset cleared idx5", 8'h00);
        frame({8'h42, mk(0, 1, 0, 4'd2, 0)}, 16);
        peek(4'd2, "R10 frame after new rise", 8'h42);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        wclk(4);
        rst = 1'b0;
        wclk(3);
        t_reset_state();
        t_basic_write();
        t_select_mismatch();
        t_broadcast();
        t_short_write();
        t_long_write();
        t_addr_abort();
        t_read(4'd5, 8'hA5);
        t_read(4'd3, 8'h3C);
        t_read_abort();
        t_reset_mid_frame();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule